// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Flags

This block sits beside a shared two-port memory and turns accesses to two reserved words at the very top of its address space into one interrupt flag per port. Each port (left and right) presents an enable, a write strobe, a read strobe and an address every clock cycle, together with the busy flag that the memory's arbiter returns to that port. The block decodes mailbox hits, sets or clears the flags, and drives two active-low interrupt outputs.

The topmost address (all ones) is the right port's mailbox and the address one below it is the left port's mailbox. When one port writes the other port's mailbox, the other port's interrupt goes active. When a port reads its own mailbox, its interrupt is released. A port whose busy flag is active can do neither. The mailbox contents are held by the memory itself and are not part of this block.

Top module: `mbx_irq_flags`

## Requirements
- R1: While `rst` is high at a clock edge, both `lt_irq_n` and `rt_irq_n` are 1 after that edge.
- R2: A left write (`lt_en`=1, `lt_wr`=1) to address all-ones with `lt_busy`=0 drives `rt_irq_n` to 0 after the same clock edge.
- R3: A right write to address all-ones minus one with `rt_busy`=0 drives `lt_irq_n` to 0 after the same clock edge.
- R4: A port's read (`en`=1, `wr`=0, `rd`=1) of its own mailbox with its busy at 0 returns that port's `irq_n` to 1 after the same edge; only that port can clear its flag.
- R5: A port's read of the other port's mailbox changes neither interrupt output.
- R6: While a port's busy is 1, its write to the other port's mailbox does not set the other port's interrupt.
- R7: While a port's busy is 1, its read of its own mailbox does not clear its own interrupt.
- R8: A write by a port to its own mailbox neither sets nor clears any interrupt.
- R9: When a flag is set and cleared in the same cycle, it ends up set (`irq_n`=0).
- R10: With `en`=0 an access has no effect; with `en`=1 and `wr`=1 the access is a write whatever `rd` is; addresses other than the two mailbox words have no effect.
- R11: The mailbox addresses follow the parameter `ADDR_W`: right mailbox = 2^ADDR_W-1, left mailbox = 2^ADDR_W-2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lt_en | input | 1 | Left port access enable |
| lt_wr | input | 1 | Left port write strobe |
| lt_rd | input | 1 | Left port read strobe |
| lt_addr | input | ADDR_W | Left port address |
| lt_busy | input | 1 | Arbiter busy returned to the left port, active high |
| rt_en | input | 1 | Right port access enable |
| rt_wr | input | 1 | Right port write strobe |
| rt_rd | input | 1 | Right port read strobe |
| rt_addr | input | ADDR_W | Right port address |
| rt_busy | input | 1 | Arbiter busy returned to the right port, active high |
| lt_irq_n | output | 1 | Left port interrupt, active low |
| rt_irq_n | output | 1 | Right port interrupt, active low |

## Verification
Every result of this block is due exactly one clock edge after the access that causes it, since each flag is a single register fed by combinational decode. The bench drives a cycle's access shortly after a rising edge, lets one rising edge pass, and samples both interrupt outputs one nanosecond later, before anything else changes. A near-exhaustive sweep with a three-bit address covers every pairing of operation kind, address and busy on both ports from each of the four starting flag states, and directed cases name each requirement.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int NUM_PORTS = 2;
    localparam int NUM_FLAGS = 2;

    typedef enum logic [0:0] {
        SIDE_LT = 1'b0,
        SIDE_RT = 1'b1
    } side_e;

    // Decoded mailbox hits of one port, already gated by that port's busy.
    typedef struct packed {
        logic wr_top;   // write of the all-ones word
        logic wr_sub;   // write of the all-ones-minus-one word
        logic rd_top;   // read of the all-ones word
        logic rd_sub;   // read of the all-ones-minus-one word
    } mbx_hit_t;

    // Raw request of one port.
    typedef struct packed {
        logic en;
        logic wr;
        logic rd;
        logic busy;
    } mbx_ctl_t;

    // Resolve a request into write / read qualifiers; a write wins over a read.
    function automatic logic [1:0] mbx_kind(input mbx_ctl_t c);
        logic is_wr;
        logic is_rd;
        is_wr = c.en & c.wr;
        is_rd = c.en & c.rd & ~c.wr;
        return {is_wr, is_rd};
    endfunction

endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
    import mbx_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  mbx_ctl_t            ctl,
    input  logic [ADDR_W-1:0]   addr,
    output mbx_hit_t            hit
);
    localparam logic [ADDR_W-1:0] TOP_WORD = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] SUB_WORD = {{(ADDR_W-1){1'b1}}, 1'b0};

    logic [1:0] kind;
    logic       at_top;
    logic       at_sub;
    logic       free;

    always_comb begin
        kind   = mbx_kind(ctl);
        at_top = (addr == TOP_WORD);
        at_sub = (addr == SUB_WORD);
        free   = ~ctl.busy;
        hit.wr_top = free & kind[1] & at_top;
        hit.wr_sub = free & kind[1] & at_sub;
        hit.rd_top = free & kind[0] & at_top;
        hit.rd_sub = free & kind[0] & at_sub;
    end

endmodule

// File: rtl/mbx_flag_cell.sv
module mbx_flag_cell (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    always_ff @(posedge clk) begin
        if (rst)
            flag_o <= 1'b0;
        else if (set_i)
            flag_o <= 1'b1;
        else if (clr_i)
            flag_o <= 1'b0;
    end

    // R9: a set in the same cycle as a clear leaves the flag raised
    a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
        set_i |=> flag_o);

    // R4: a clear with no competing set drops the flag
    a_r4_clear_drops: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !set_i) |=> !flag_o);

    // R10: with neither request the flag keeps its value
    a_r10_flag_holds: assert property (@(posedge clk) disable iff (rst)
        (!set_i && !clr_i) |=> $stable(flag_o));

endmodule

// File: rtl/mbx_irq_flags.sv
module mbx_irq_flags
    import mbx_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lt_en,
    input  logic              lt_wr,
    input  logic              lt_rd,
    input  logic [ADDR_W-1:0] lt_addr,
    input  logic              lt_busy,
    input  logic              rt_en,
    input  logic              rt_wr,
    input  logic              rt_rd,
    input  logic [ADDR_W-1:0] rt_addr,
    input  logic              rt_busy,
    output logic              lt_irq_n,
    output logic              rt_irq_n
);
    mbx_ctl_t          ctl  [NUM_PORTS];
    logic [ADDR_W-1:0] addr [NUM_PORTS];
    mbx_hit_t          hit  [NUM_PORTS];
    logic              set_v [NUM_FLAGS];
    logic              clr_v [NUM_FLAGS];
    logic              flag  [NUM_FLAGS];

    always_comb begin
        ctl[SIDE_LT]  = '{en: lt_en, wr: lt_wr, rd: lt_rd, busy: lt_busy};
        ctl[SIDE_RT]  = '{en: rt_en, wr: rt_wr, rd: rt_rd, busy: rt_busy};
        addr[SIDE_LT] = lt_addr;
        addr[SIDE_RT] = rt_addr;
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_dec
        mbx_port_decode #(.ADDR_W(ADDR_W)) u_dec (
            .ctl  (ctl[p]),
            .addr (addr[p]),
            .hit  (hit[p])
        );
    end

    // Flag index follows the owning side: the left flag lives in the
    // lower word, the right flag in the top word.
    always_comb begin
        set_v[SIDE_LT] = hit[SIDE_RT].wr_sub;
        clr_v[SIDE_LT] = hit[SIDE_LT].rd_sub;
        set_v[SIDE_RT] = hit[SIDE_LT].wr_top;
        clr_v[SIDE_RT] = hit[SIDE_RT].rd_top;
    end

    for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
        mbx_flag_cell u_cell (
            .clk    (clk),
            .rst    (rst),
            .set_i  (set_v[f]),
            .clr_i  (clr_v[f]),
            .flag_o (flag[f])
        );
    end

    assign lt_irq_n = ~flag[SIDE_LT];
    assign rt_irq_n = ~flag[SIDE_RT];

    // R1: reset releases both interrupts
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (lt_irq_n && rt_irq_n));

    // R6: a busy left port cannot raise the right interrupt
    a_r6_busy_lt_no_set: assert property (@(posedge clk) disable iff (rst)
        (lt_busy && rt_irq_n) |=> rt_irq_n);

    // R6: a busy right port cannot raise the left interrupt
    a_r6_busy_rt_no_set: assert property (@(posedge clk) disable iff (rst)
        (rt_busy && lt_irq_n) |=> lt_irq_n);

    // R7: a busy right port cannot release its own interrupt
    a_r7_busy_rt_no_clr: assert property (@(posedge clk) disable iff (rst)
        (rt_busy && !rt_irq_n) |=> !rt_irq_n);

    // R7: a busy left port cannot release its own interrupt
    a_r7_busy_lt_no_clr: assert property (@(posedge clk) disable iff (rst)
        (lt_busy && !lt_irq_n) |=> !lt_irq_n);

    // R4: only the right port releases the right interrupt
    a_r4_rt_owner_only: assert property (@(posedge clk) disable iff (rst)
        (!rt_en && !rt_irq_n) |=> !rt_irq_n);

    // R4: only the left port releases the left interrupt
    a_r4_lt_owner_only: assert property (@(posedge clk) disable iff (rst)
        (!lt_en && !lt_irq_n) |=> !lt_irq_n);

endmodule

// File: tb/mbx_irq_flags_bench.sv
module mbx_irq_flags_bench;
    localparam int AW = 3;
    localparam logic [AW-1:0] TOP = 3'd7;
    localparam logic [AW-1:0] SUB = 3'd6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic le = 0, lw = 0, lr = 0, lb = 0;
    logic re = 0, rw = 0, rr = 0, rb = 0;
    logic [AW-1:0] la = '0, ra = '0;
    logic lt_irq_n, rt_irq_n;

    int n_cmp = 0;
    int n_bad = 0;
    logic exp_l = 1'b0;   // expected flags, active high
    logic exp_r = 1'b0;

    always #4 clk = ~clk;

    mbx_irq_flags #(.ADDR_W(AW)) u_mbx_irq_flags (
        .clk(clk), .rst(rst),
        .lt_en(le), .lt_wr(lw), .lt_rd(lr), .lt_addr(la), .lt_busy(lb),
        .rt_en(re), .rt_wr(rw), .rt_rd(rr), .rt_addr(ra), .rt_busy(rb),
        .lt_irq_n(lt_irq_n), .rt_irq_n(rt_irq_n)
    );

    // op: 0 = disabled (wr, rd high), 1 = read, 2 = write, 3 = wr+rd
    task automatic set_port(input bit left, input int op,
                            input logic [AW-1:0] a, input logic b);
        logic e, w, r;
        e = (op != 0);
        w = (op == 0) || (op >= 2);
        r = (op != 2);
        if (left) begin le = e; lw = w; lr = r; la = a; lb = b; end
        else      begin re = e; rw = w; rr = r; ra = a; rb = b; end
    endtask

    task automatic idle();
        le = 0; lw = 0; lr = 0; lb = 0; la = '0;
        re = 0; rw = 0; rr = 0; rb = 0; ra = '0;
    endtask

    // Expected next flags from the requirements.
    task automatic model();
        logic lwx, lrx, rwx, rrx, sl, cl, sr, cr;
        lwx = le & lw;  lrx = le & lr & ~lw;
        rwx = re & rw;  rrx = re & rr & ~rw;
        sr = lwx & (la == TOP) & ~lb;   // R2
        cr = rrx & (ra == TOP) & ~rb;   // R4
        sl = rwx & (ra == SUB) & ~rb;   // R3
        cl = lrx & (la == SUB) & ~lb;   // R4
        exp_r = sr | (exp_r & ~cr);
        exp_l = sl | (exp_l & ~cl);
    endtask

    task automatic step();
        if (rst) begin exp_l = 0; exp_r = 0; end
        else model();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag);
        n_cmp++;
        if (lt_irq_n !== ~exp_l || rt_irq_n !== ~exp_r) begin
            n_bad++;
            $display("FAIL %s: lt_irq_n=%b rt_irq_n=%b expected %b %b",
                     tag, lt_irq_n, rt_irq_n, ~exp_l, ~exp_r);
        end
    endtask

    task automatic do_reset();
        idle(); rst = 1; step(); rst = 0;
    endtask

    task automatic raise_both();
        idle();
        set_port(1, 2, TOP, 0);
        set_port(0, 2, SUB, 0);
        step();
    endtask

    initial begin
        @(posedge clk); #1;
        do_reset();
        check("R1 reset");

        set_port(1, 2, TOP, 0); step(); check("R2 left write top sets right");
        idle(); set_port(0, 2, SUB, 0); step(); check("R3 right write sub sets left");
        idle(); set_port(1, 1, TOP, 0); set_port(0, 1, SUB, 0); step();
        check("R5 cross reads leave flags");
        idle(); set_port(1, 2, SUB, 0); set_port(0, 2, TOP, 0); step();
        check("R8 own mailbox writes ignored");
        idle(); set_port(1, 1, SUB, 1); set_port(0, 1, TOP, 1); step();
        check("R7 busy reads keep flags");
        idle(); set_port(0, 1, TOP, 0); step(); check("R4 right read clears right");
        idle(); set_port(1, 3, SUB, 0); step(); check("R10 wr+rd is a write, no clear");
        idle(); set_port(1, 1, SUB, 0); step(); check("R4 left read clears left");
        idle(); set_port(1, 2, TOP, 1); set_port(0, 2, SUB, 1); step();
        check("R6 busy writes do not set");
        idle(); set_port(1, 0, TOP, 0); set_port(0, 0, SUB, 0); step();
        check("R10 disabled strobes ignored");
        idle(); set_port(1, 2, 3'd5, 0); set_port(0, 2, 3'd5, 0); step();
        check("R11 non-mailbox address ignored");
        raise_both();
        idle(); set_port(1, 2, TOP, 0); set_port(0, 1, TOP, 0); step();
        check("R9 set beats clear on right flag");
        idle(); rst = 1; step(); rst = 0; check("R1 reset after flags raised");

        // Near-exhaustive sweep from each starting state.
        for (int init = 0; init < 4; init++)
          for (int lop = 0; lop < 4; lop++)
            for (int lai = 0; lai < 8; lai++)
              for (int lbi = 0; lbi < 2; lbi++)
                for (int rop = 0; rop < 4; rop++)
                  for (int rai = 0; rai < 8; rai++)
                    for (int rbi = 0; rbi < 2; rbi++) begin
                        do_reset();
                        if (init != 0) begin
                            idle();
                            if (init[1]) set_port(1, 2, TOP, 0);
                            if (init[0]) set_port(0, 2, SUB, 0);
                            step();
                        end
                        set_port(1, lop, AW'(lai), 1'(lbi));
                        set_port(0, rop, AW'(rai), 1'(rbi));
                        step();
                        check("sweep R2/R3/R4/R5/R6/R7/R8/R9/R10/R11");
                    end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule